// File: doc/BRIEF.md
# Divide instruction decode and register-stack control

This block sits at the front of a stack-organised floating-point unit and handles the divide family of instructions. It looks at an opcode byte and its ModR/M byte. For a divide it reports which kind of source the instruction uses, and it maps the stack-relative operands and the destination onto physical register numbers. It also says whether the instruction pops the stack. The decode is combinational and appears in the same cycle as the issue strobe.

The block owns the architectural top-of-stack pointer and the eight-entry tag array, where each bit means "register holds a value". It flags a stack underflow when an issued divide names an empty register. A pop is applied on the clock edge that ends the issue cycle. The pop only happens if the exception logic has not blocked the store of the result. It clears the tag of the register at the top and advances the pointer by one, modulo 8. Arithmetic, memory access and integer conversion are handled elsewhere.

Top module: `fdiv_stack_ctl`

## Requirements
- R1: After reset the stack pointer equals parameter RESET_TOP and the tag array equals RESET_TAGS (defaults 0 and 8'hFF, bit n = 1 meaning physical register n is occupied).
- R2: With mod != 3 and reg field 6, opcodes D8, DC, DA and DE decode as divides. Their src_kind is 1 (32-bit float), 2 (64-bit float), 3 (32-bit integer) and 4 (16-bit integer) respectively. Dividend and destination are ST(0), and the instruction does not pop.
- R3: D8 with ModR/M F0+i decodes with src_kind 0 (register). Dividend is ST(0), divisor is ST(i), destination is ST(0), and there is no pop.
- R4: DC with ModR/M F8+i decodes with src_kind 0. Dividend is ST(i), divisor is ST(0), destination is ST(i), and there is no pop.
- R5: DE with ModR/M F8+i decodes like R4 but with pop asserted. DE F9 therefore divides ST(1) by ST(0), writes ST(1) and pops.
- R6: Every reported register index is the physical number (top + i) mod 8 for stack slot ST(i).
- R7: When pop is asserted and store_blocked is low, then on the next edge the tag of the register that was ST(0) is cleared and top becomes (top + 1) mod 8.
- R8: When store_blocked is high during a popping divide, top and the tags stay unchanged.
- R9: stk_underflow is high exactly when an issued divide finds its dividend register empty, or, for register forms only, its divisor register empty.
- R10: Any other opcode or ModR/M combination gives is_div = 0, pop = 0 and stk_underflow = 0, and leaves top and the tags unchanged. This includes memory-form opcodes whose reg field is not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModR/M byte |
| store_blocked | input | 1 | Unmasked exception suppresses the store (and therefore the pop) |
| is_div | output | 1 | Issued instruction is a divide |
| src_kind | output | 3 | 0 register, 1 f32, 2 f64, 3 i32, 4 i16 |
| dvd_reg | output | 3 | Physical register of the dividend |
| dvs_reg | output | 3 | Physical register of the divisor (register forms) |
| dst_reg | output | 3 | Physical register receiving the quotient |
| pop | output | 1 | Divide pops the stack after storing |
| stk_underflow | output | 1 | Referenced register is empty |
| top | output | 3 | Current top-of-stack pointer |
| tag_valid | output | 8 | Occupancy bit per physical register |

## Verification
A wrong pointer or tag bit shows up at the ports in the very next cycle. top and tag_valid are visible directly. Every index reported for a later instruction then lands on the wrong physical register, and stk_underflow fires on occupied registers or stays silent on empty ones. A pop that is lost or doubled leaves top off by one for the rest of the run, so every later register-form decode disagrees with the bench's model.

// File: rtl/fdiv_stack_ctl.sv
module fdiv_stack_ctl #(
  parameter logic [2:0] RESET_TOP  = 3'd0,
  parameter logic [7:0] RESET_TAGS = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  input  logic       store_blocked,
  output logic       is_div,
  output logic [2:0] src_kind,
  output logic [2:0] dvd_reg,
  output logic [2:0] dvs_reg,
  output logic [2:0] dst_reg,
  output logic       pop,
  output logic       stk_underflow,
  output logic [2:0] top,
  output logic [7:0] tag_valid
);
  localparam logic [2:0] K_REG = 3'd0, K_F32 = 3'd1, K_F64 = 3'd2,
                         K_I32 = 3'd3, K_I16 = 3'd4;

  logic       reg_form;
  logic [2:0] regf, rm;
  logic       dec_div, dec_pop;
  logic [2:0] kind, dvd_off, dvs_off, dst_off;

  assign reg_form = modrm[7:6] == 2'b11;
  assign regf     = modrm[5:3];
  assign rm       = modrm[2:0];

  always_comb begin
    dec_div = 1'b0;
    dec_pop = 1'b0;
    kind    = K_REG;
    dvd_off = 3'd0;
    dvs_off = 3'd0;
    dst_off = 3'd0;
    case (opcode)
      8'hD8:
        if (reg_form) begin
          if (regf == 3'd6) begin
            dec_div = 1'b1;
            dvs_off = rm;
          end
        end else if (regf == 3'd6) begin
          dec_div = 1'b1;
          kind    = K_F32;
        end
      8'hDC:
        if (reg_form) begin
          if (regf == 3'd7) begin
            dec_div = 1'b1;
            dvd_off = rm;
            dst_off = rm;
          end
        end else if (regf == 3'd6) begin
          dec_div = 1'b1;
          kind    = K_F64;
        end
      8'hDA:
        if (!reg_form && regf == 3'd6) begin
          dec_div = 1'b1;
          kind    = K_I32;
        end
      8'hDE:
        if (reg_form) begin
          if (regf == 3'd7) begin
            dec_div = 1'b1;
            dec_pop = 1'b1;
            dvd_off = rm;
            dst_off = rm;
          end
        end else if (regf == 3'd6) begin
          dec_div = 1'b1;
          kind    = K_I16;
        end
      default: ;
    endcase
  end

  assign is_div   = issue & dec_div;
  assign src_kind = kind;
  assign dvd_reg  = top + dvd_off;
  assign dvs_reg  = top + dvs_off;
  assign dst_reg  = top + dst_off;
  assign pop      = is_div & dec_pop;
  assign stk_underflow = is_div &
         (~tag_valid[dvd_reg] | ((kind == K_REG) & ~tag_valid[dvs_reg]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top       <= RESET_TOP;
      tag_valid <= RESET_TAGS;
    end else if (pop && !store_blocked) begin
      tag_valid[top] <= 1'b0;
      top            <= top + 3'd1;
    end
  end
endmodule

module fdiv_stack_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_div,
  input logic [2:0] src_kind,
  input logic       pop,
  input logic       store_blocked,
  input logic       stk_underflow,
  input logic [2:0] top,
  input logic [7:0] tag_valid
);
  assert_mem_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && src_kind != 3'd0) |-> !pop);
  assert_pop_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !store_blocked) |=> top == $past(top) + 3'd1);
  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !store_blocked) |=> !tag_valid[$past(top)]);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && !store_blocked) |=> $stable(top) && $stable(tag_valid));
  assert_uflow_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_underflow |-> is_div);
  assert_nondiv_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_div |-> (!pop && !stk_underflow));
endmodule

bind fdiv_stack_ctl fdiv_stack_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_div(is_div), .src_kind(src_kind), .pop(pop),
  .store_blocked(store_blocked), .stk_underflow(stk_underflow),
  .top(top), .tag_valid(tag_valid)
);

// File: tb/fdiv_stack_ctl_test.sv
module fdiv_stack_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] modrm = 8'h00;
  logic       store_blocked = 1'b0;
  logic       is_div, pop, stk_underflow;
  logic [2:0] src_kind, dvd_reg, dvs_reg, dst_reg, top;
  logic [7:0] tag_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_top;
  bit m_tag [8];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdiv_stack_ctl uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .modrm(modrm),
    .store_blocked(store_blocked), .is_div(is_div), .src_kind(src_kind),
    .dvd_reg(dvd_reg), .dvs_reg(dvs_reg), .dst_reg(dst_reg), .pop(pop),
    .stk_underflow(stk_underflow), .top(top), .tag_valid(tag_valid)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (op=%h modrm=%h)", req, act, exp, opcode, modrm);
    end
  endtask

  function automatic int tags_word();
    int w = 0;
    for (int k = 0; k < 8; k++) if (m_tag[k]) w |= (1 << k);
    return w;
  endfunction

  task automatic step(logic [7:0] op, logic [7:0] mr, bit blk);
    int e_div, e_kind, e_dvd, e_dvs, e_dst, e_pop, e_uf, md, rf, r;
    string req;
    @(negedge clk);
    issue = 1'b1; opcode = op; modrm = mr; store_blocked = blk;
    chk("R7 top", top, m_top);
    chk("R7 tags", tag_valid, tags_word());
    md = mr[7:6]; rf = mr[5:3]; r = mr[2:0];
    e_div = 0; e_kind = 0; e_dvd = 0; e_dvs = 0; e_dst = 0; e_pop = 0;
    req = "R10";
    if (md != 3 && rf == 6) begin
      if (op == 8'hD8) begin e_div = 1; e_kind = 1; end
      if (op == 8'hDC) begin e_div = 1; e_kind = 2; end
      if (op == 8'hDA) begin e_div = 1; e_kind = 3; end
      if (op == 8'hDE) begin e_div = 1; e_kind = 4; end
      if (e_div != 0) req = "R2";
    end else if (md == 3) begin
      if (op == 8'hD8 && rf == 6) begin e_div = 1; e_dvs = r; req = "R3/R6"; end
      if (op == 8'hDC && rf == 7) begin e_div = 1; e_dvd = r; e_dst = r; req = "R4/R6"; end
      if (op == 8'hDE && rf == 7) begin e_div = 1; e_dvd = r; e_dst = r; e_pop = 1; req = "R5/R6"; end
    end
    e_dvd = (m_top + e_dvd) % 8;
    e_dvs = (m_top + e_dvs) % 8;
    e_dst = (m_top + e_dst) % 8;
    e_uf = e_div && (!m_tag[e_dvd] || (e_kind == 0 && !m_tag[e_dvs]));
    #1;
    chk(req, is_div, e_div);
    chk(req, pop, e_pop);
    chk("R9 underflow", stk_underflow, e_uf);
    if (e_div != 0) begin
      chk(req, src_kind, e_kind);
      chk(req, dvd_reg, e_dvd);
      chk(req, dst_reg, e_dst);
      if (e_kind == 0) chk(req, dvs_reg, e_dvs);
    end
    if (e_pop != 0 && !blk) begin
      m_tag[m_top] = 0;
      m_top = (m_top + 1) % 8;
    end
    @(negedge clk);
    issue = 1'b0;
    if (e_pop != 0 && blk) chk("R8 hold", top, m_top);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_top = 0;
    for (int k = 0; k < 8; k++) m_tag[k] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 top", top, 0);
    chk("R1 tags", tag_valid, 255);

    step(8'hD8, 8'h30, 0);
    step(8'hDC, 8'h75, 0);
    step(8'hDA, 8'hB2, 0);
    step(8'hDE, 8'h30, 0);
    step(8'hD8, 8'h20, 0);
    step(8'hDE, 8'h38, 0);
    step(8'hDA, 8'hF0, 0);
    step(8'hD9, 8'hF8, 0);
    step(8'hD8, 8'hF3, 0);
    step(8'hDC, 8'hFA, 0);
    step(8'hDC, 8'hF2, 0);
    step(8'hDE, 8'hF9, 1);
    step(8'hDE, 8'hFD, 0);
    step(8'hDE, 8'hF9, 0);
    step(8'hD8, 8'hF7, 0);
    step(8'hD8, 8'hF2, 0);
    step(8'hD8, 8'h30, 0);
    for (int n = 0; n < 9; n++) step(8'hDE, 8'hF9, 0);
    step(8'hDC, 8'h30, 0);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_top = 0;
    for (int k = 0; k < 8; k++) m_tag[k] = 1;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op, mr;
      seed = seed * 32'd1103515245 + 32'd12345;
      case (seed[18:16] % 5)
        0: op = 8'hD8;
        1: op = 8'hDC;
        2: op = 8'hDA;
        3: op = 8'hDE;
        default: op = 8'hD9;
      endcase
      mr = seed[31:24];
      if (seed[20]) mr[5:3] = seed[21] ? 3'd7 : 3'd6;
      step(op, mr, seed[23:22] == 2'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule